// File: doc/BRIEF.md
# Serial Wire Bit Sequence Shifter

This block moves a bit stream of programmable length across one bidirectional debug data line while it generates the matching debug clock. The line itself is split into three pins: data out, data in and an output enable that an external pad cell combines. A request is started with a one-cycle `start` pulse together with the mode, the direction flag, the bit count and the clock timing. `busy` stays high while the burst runs and `done` pulses once when it ends.

There are two modes. The line-reset mode always drives the line. Its length is a full-width count, which suits long reset and selection streams. The raw mode carries a short burst of 1 to 64 bits in either direction. In capture mode the line is released and the sampled bits come back as packed bytes. Driven data is fetched a byte at a time from `byteIn`, least-significant bit first. `byteTake` marks each edge at which a byte is consumed.

Each bit is one full clock period. The clock is low for H system cycles and then high for H cycles. H is `halfDelay + 1`, or exactly 1 when `fastClk` is set. Between bursts the clock is parked high and the output enable is asserted.

Top module: `swBitShifter`

## Requirements
- R1: In raw mode (`lineMode`=0) only `bitCount[5:0]` is used. A value of 0 there means 64 bits, any other value is the number of bits, and the upper count bits are ignored.
- R2: In line-reset mode (`lineMode`=1) the full `bitCount` gives the number of bits and the direction flag is ignored. A count of 0 produces no clock edge and still pulses `done`.
- R3: Driven bits leave LSB first. Bit 0 of the first byte goes first. `byteIn` is latched at the start and again after every 8 bits, and `byteTake` is high in the cycle before each such latch edge.
- R4: Every bit is one clock period: H cycles low followed by H cycles high, where H = `halfDelay`+1, or H = 1 when `fastClk`=1.
- R5: `swdo` changes only while `swclk` is low. It never changes in a cycle where the clock was high and stays high.
- R6: In raw capture mode (`capDir`=1) `swdi` is sampled on the last system cycle of each low phase. The bits are packed into bytes with the earliest bit at bit 0, and a final partial byte is right-aligned with its unused upper bits zero. Each byte is presented on `byteOut` with a one-cycle `byteValid`.
- R7: While busy, `swoe` is 0 for a raw capture burst and 1 for any driving burst, and it does not change during the burst.
- R8: `busy` rises in the cycle after an accepted `start`. `done` is high for exactly one cycle, right after the last cycle of the final high phase, and `busy` falls in that same cycle.
- R9: A `start` pulse while `busy` is high has no effect on the running burst.
- R10: Out of reset and between bursts, `swclk` and `swoe` are 1 and `busy`, `done` and `byteValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a burst (ignored while busy) |
| lineMode | input | 1 | 1 = line-reset mode, 0 = raw mode |
| capDir | input | 1 | Raw mode: 1 = capture, 0 = drive |
| bitCount | input | 16 | Bit count (raw mode uses bits 5:0) |
| halfDelay | input | 8 | Half-period is halfDelay+1 cycles |
| fastClk | input | 1 | Half-period forced to one cycle |
| byteIn | input | 8 | Next byte to drive |
| byteTake | output | 1 | byteIn is latched at the coming edge |
| byteOut | output | 8 | Captured byte |
| byteValid | output | 1 | byteOut is valid this cycle |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| swclk | output | 1 | Debug clock |
| swdo | output | 1 | Line data out |
| swdi | input | 1 | Line data in |
| swoe | output | 1 | Line output enable |

## Verification
The assertions assume that `start` is a clean synchronous level and that the configuration inputs are steady while `start` is high. They also assume that the target holds `swdi` steady from the cycle after the clock falls until it rises again. The bench changes every input half a cycle away from the active edge. It holds the configuration for the whole request. It moves `swdi` only at the negative edge that follows a detected clock fall, so the value is settled before the sampling edge even when H is 1.

// File: rtl/swBitPkg.sv
package swBitPkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_DONE
  } stateT;

  typedef struct packed {
    logic loadByte;
    logic nextBit;
    logic sample;
    logic lastBit;
  } strobeT;
endpackage

// File: rtl/swBitCtrl.sv
module swBitCtrl
  import swBitPkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DLY_W  = 8,
  parameter int RAW_W  = 6,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             lineMode,
  input  logic             capDir,
  input  logic [CNT_W-1:0] bitCount,
  input  logic [DLY_W-1:0] halfDelay,
  input  logic             fastClk,
  output strobeT           strb,
  output logic             byteTake,
  output logic             busy,
  output logic             done,
  output logic             swclk,
  output logic             swoe
);
  localparam int IDX_W   = $clog2(BYTE_W);
  localparam int RAW_MAX = 1 << RAW_W;

  stateT            state;
  logic [DLY_W-1:0] phaseCnt;
  logic [DLY_W-1:0] hLat;
  logic [CNT_W-1:0] bitsLeft;
  logic [IDX_W-1:0] bitIdx;
  logic             capLat;

  logic [RAW_W-1:0] rawField;
  logic [CNT_W-1:0] total;
  logic [DLY_W-1:0] phaseNow;
  logic [IDX_W-1:0] bitIdxInc;
  logic accept, capNow, endHigh, contNext, firstBit;

  always_comb begin
    rawField  = bitCount[RAW_W-1:0];
    total     = lineMode ? bitCount
              : ((rawField == '0) ? CNT_W'(RAW_MAX) : CNT_W'(rawField));
    phaseNow  = fastClk ? '0 : halfDelay;
    accept    = start && (state == ST_IDLE || state == ST_DONE);
    capNow    = !lineMode && capDir;
    endHigh   = (state == ST_HIGH) && (phaseCnt == '0);
    contNext  = endHigh && (bitsLeft != CNT_W'(1));
    firstBit  = accept && (total != '0);
    bitIdxInc = bitIdx + 1'b1;
    strb.loadByte = (firstBit && !capNow) ||
                    (contNext && !capLat && bitIdxInc == '0);
    strb.nextBit  = contNext && !capLat && (bitIdxInc != '0);
    strb.sample   = (state == ST_LOW) && (phaseCnt == '0) && capLat;
    strb.lastBit  = (bitsLeft == CNT_W'(1));
    byteTake = strb.loadByte;
    busy     = (state == ST_LOW) || (state == ST_HIGH);
    done     = (state == ST_DONE);
    swoe     = !(busy && capLat);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      hLat     <= '0;
      bitsLeft <= '0;
      bitIdx   <= '0;
      capLat   <= 1'b0;
      swclk    <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (accept) begin
            capLat   <= capNow;
            hLat     <= phaseNow;
            bitsLeft <= total;
            bitIdx   <= '0;
            phaseCnt <= phaseNow;
            if (total == '0) begin
              state <= ST_DONE;
            end else begin
              state <= ST_LOW;
              swclk <= 1'b0;
            end
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_LOW: begin
          if (phaseCnt == '0) begin
            state    <= ST_HIGH;
            swclk    <= 1'b1;
            phaseCnt <= hLat;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        ST_HIGH: begin
          if (phaseCnt == '0) begin
            bitIdx   <= bitIdxInc;
            bitsLeft <= bitsLeft - 1'b1;
            if (bitsLeft == CNT_W'(1)) begin
              state <= ST_DONE;
            end else begin
              state    <= ST_LOW;
              swclk    <= 1'b0;
              phaseCnt <= hLat;
            end
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (swclk && swoe)); // R10
  AST_OE_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(swoe)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> !done); // R8
  AST_BUSY_TO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    busy && start |=> (busy || done)); // R9
endmodule

// File: rtl/swBitPath.sv
module swBitPath
  import swBitPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic              swclk,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic              swdi,
  output logic              swdo,
  output logic [BYTE_W-1:0] byteOut,
  output logic              byteValid
);
  localparam int IDX_W = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shReg;
  logic [BYTE_W-1:0] capReg;
  logic [BYTE_W-1:0] nextCap;
  logic [IDX_W-1:0]  fill;
  logic              flush;

  always_comb begin
    nextCap = {swdi, capReg[BYTE_W-1:1]};
    flush   = strb.sample && ((fill == TOP_IDX) || strb.lastBit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      swdo  <= 1'b1;
    end else if (strb.loadByte) begin
      shReg <= byteIn;
      swdo  <= byteIn[0];
    end else if (strb.nextBit) begin
      shReg <= shReg >> 1;
      swdo  <= shReg[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capReg    <= '0;
      fill      <= '0;
      byteOut   <= '0;
      byteValid <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      if (flush) begin
        byteOut   <= nextCap >> (TOP_IDX - fill);
        byteValid <= 1'b1;
        capReg    <= '0;
        fill      <= '0;
      end else if (strb.sample) begin
        capReg <= nextCap;
        fill   <= fill + 1'b1;
      end
    end
  end

  AST_SWDO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    swclk && $past(swclk) |-> $stable(swdo)); // R5
  AST_VALID_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> $past(strb.sample)); // R6
endmodule

// File: rtl/swBitShifter.sv
module swBitShifter
  import swBitPkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DLY_W  = 8,
  parameter int RAW_W  = 6,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              lineMode,
  input  logic              capDir,
  input  logic [CNT_W-1:0]  bitCount,
  input  logic [DLY_W-1:0]  halfDelay,
  input  logic              fastClk,
  input  logic [BYTE_W-1:0] byteIn,
  output logic              byteTake,
  output logic [BYTE_W-1:0] byteOut,
  output logic              byteValid,
  output logic              busy,
  output logic              done,
  output logic              swclk,
  output logic              swdo,
  input  logic              swdi,
  output logic              swoe
);
  strobeT strb;

  swBitCtrl #(
    .CNT_W(CNT_W), .DLY_W(DLY_W), .RAW_W(RAW_W), .BYTE_W(BYTE_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .lineMode(lineMode),
    .capDir(capDir), .bitCount(bitCount), .halfDelay(halfDelay),
    .fastClk(fastClk), .strb(strb), .byteTake(byteTake), .busy(busy),
    .done(done), .swclk(swclk), .swoe(swoe)
  );

  swBitPath #(.BYTE_W(BYTE_W)) i_path (
    .clk(clk), .rstN(rstN), .strb(strb), .swclk(swclk), .byteIn(byteIn),
    .swdi(swdi), .swdo(swdo), .byteOut(byteOut), .byteValid(byteValid)
  );
endmodule

// File: tb/test_swBitShifter.sv
module test_swBitShifter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        lineMode = 1'b0;
  logic        capDir = 1'b0;
  logic [15:0] bitCount = '0;
  logic [7:0]  halfDelay = '0;
  logic        fastClk = 1'b0;
  logic [7:0]  byteIn;
  logic        byteTake, byteValid, busy, done, swclk, swdo, swdi, swoe;
  logic [7:0]  byteOut;

  always #4 clk = ~clk;

  swBitShifter i_swBitShifter (
    .clk(clk), .rstN(rstN), .start(start), .lineMode(lineMode),
    .capDir(capDir), .bitCount(bitCount), .halfDelay(halfDelay),
    .fastClk(fastClk), .byteIn(byteIn), .byteTake(byteTake),
    .byteOut(byteOut), .byteValid(byteValid), .busy(busy), .done(done),
    .swclk(swclk), .swdo(swdo), .swdi(swdi), .swoe(swoe)
  );

  int checks = 0;
  int errors = 0;

  // stimulus owned by the tasks
  logic [63:0] curData = '0;
  logic        expOe = 1'b1;

  // monitor state, owned by the negedge block
  int          rises, falls, feedIdx, driveErr, oeErr, capBytes, doneCnt;
  int          lowLen, lastLow;
  logic [5:0]  bitPos;
  logic [63:0] capVec;
  logic        prevClk, takeSeen;
  longint      cycles = 0;

  assign byteIn = curData[8*(feedIdx % 8) +: 8];
  assign swdi   = curData[bitPos];

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected <150000", cycles);
      summary();
    end
  end

  always @(negedge clk) begin
    if (!rstN) begin
      rises = 0; falls = 0; feedIdx = 0; driveErr = 0; oeErr = 0;
      capBytes = 0; doneCnt = 0; lowLen = 0; lastLow = 0; bitPos = '0;
      capVec = '0; prevClk = 1'b1; takeSeen = 1'b0;
    end else if (start && !busy) begin
      rises = 0; falls = 0; feedIdx = 0; driveErr = 0; oeErr = 0;
      capBytes = 0; doneCnt = 0; lowLen = 0; lastLow = 0; bitPos = '0;
      capVec = '0; prevClk = swclk; takeSeen = byteTake;
    end else begin
      if (takeSeen) feedIdx = feedIdx + 1;
      takeSeen = byteTake;
      if (prevClk && !swclk) begin
        bitPos = falls[5:0];
        falls = falls + 1;
        lowLen = 0;
      end
      if (!swclk) lowLen = lowLen + 1;
      if (!prevClk && swclk) begin
        if (expOe && swdo !== curData[rises % 64]) driveErr = driveErr + 1;
        rises = rises + 1;
        lastLow = lowLen;
      end
      if (byteValid) begin
        if (capBytes < 8) capVec[8*capBytes +: 8] = byteOut;
        capBytes = capBytes + 1;
      end
      if (busy && swoe !== expOe) oeErr = oeErr + 1;
      if (done) doneCnt = doneCnt + 1;
      prevClk = swclk;
    end
  end

  task automatic check(input bit ok, input string req, input longint act,
                       input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int expBits(input bit lm, input logic [15:0] cnt);
    if (lm) return int'(cnt);
    return (cnt[5:0] == 0) ? 64 : int'(cnt[5:0]);
  endfunction

  task automatic launch(input bit lm, input bit cd, input logic [15:0] cnt,
                        input logic [7:0] dly, input bit fst,
                        input logic [63:0] data);
    @(posedge clk); #2;
    curData = data; lineMode = lm; capDir = cd; bitCount = cnt;
    halfDelay = dly; fastClk = fst; expOe = !(!lm && cd); start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 20000 && doneCnt == 0; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic runOne(input bit lm, input bit cd, input logic [15:0] cnt,
                        input logic [7:0] dly, input bit fst,
                        input logic [63:0] data);
    int n;
    int h;
    logic [63:0] mask;
    n = expBits(lm, cnt);
    h = fst ? 1 : int'(dly) + 1;
    launch(lm, cd, cnt, dly, fst, data);
    waitDone();
    check(rises == n, lm ? "R2 line bit count" : "R1 raw bit count",
          rises, n);
    check(doneCnt == 1, "R8 single done", doneCnt, 1);
    check(oeErr == 0, "R7 output enable", oeErr, 0);
    if (n > 0) check(lastLow == h, "R4 low phase length", lastLow, h);
    if (!lm && cd) begin
      mask = (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
      check(capVec == (data & mask), "R6 captured packing", capVec,
            data & mask);
      check(capBytes == (n + 7) / 8, "R6 byte count", capBytes, (n + 7) / 8);
    end else begin
      check(driveErr == 0, "R3 driven bit order", driveErr, 0);
    end
  endtask

  localparam int NV = 8;
  localparam bit          V_LM  [NV] = '{0, 0, 0, 0, 0, 1, 1, 0};
  localparam bit          V_CD  [NV] = '{0, 0, 1, 1, 1, 1, 0, 0};
  localparam logic [15:0] V_CNT [NV] = '{16'd5, 16'd0, 16'd13, 16'd0,
                                         16'd8, 16'd20, 16'd3, 16'h0047};
  localparam logic [7:0]  V_DLY [NV] = '{8'd2, 8'd5, 8'd1, 8'd0,
                                         8'd0, 8'd3, 8'd7, 8'd1};
  localparam bit          V_FST [NV] = '{0, 1, 0, 1, 0, 0, 1, 0};
  localparam logic [63:0] V_DAT [NV] = '{
    64'h0123_4567_89AB_CDF5, 64'hDEAD_BEEF_CAFE_F00D,
    64'h0000_0000_0000_5A3C, 64'h8000_0001_A5A5_3C3C,
    64'h0000_0000_0000_00C6, 64'h0000_0000_000F_1E2D,
    64'h0000_0000_0000_0005, 64'h0000_0000_0000_0069};

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(swclk === 1'b1, "R10 reset clock", swclk, 1);
    check(swoe === 1'b1, "R10 reset enable", swoe, 1);
    check(busy === 1'b0 && done === 1'b0, "R10 reset busy/done",
          {busy, done}, 0);
    check(byteValid === 1'b0, "R10 reset valid", byteValid, 0);
    rstN = 1'b1;
    repeat (2) @(posedge clk);

    for (int v = 0; v < NV; v++)
      runOne(V_LM[v], V_CD[v], V_CNT[v], V_DLY[v], V_FST[v], V_DAT[v]);

    // R2: zero-length line-reset burst
    runOne(1'b1, 1'b0, 16'd0, 8'd2, 1'b0, 64'h1);

    // R3: long line-reset stream with repeated byte refetch
    runOne(1'b1, 1'b0, 16'd100, 8'd0, 1'b0, 64'h7766_5544_3322_1100);

    // R8: busy timing after start
    launch(1'b0, 1'b0, 16'd4, 8'd0, 1'b1, 64'h9);
    check(busy === 1'b1, "R8 busy after start", busy, 1);
    waitDone();
    check(busy === 1'b0 && swclk === 1'b1, "R10 idle after burst",
          {busy, swclk}, 2'b01);

    // R9: start during busy is ignored
    launch(1'b0, 1'b0, 16'd40, 8'd1, 1'b0, 64'h00FF_00FF_1234_5678);
    repeat (20) @(posedge clk);
    #2;
    lineMode = 1'b1; bitCount = 16'd3; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0; lineMode = 1'b0; bitCount = 16'd40;
    waitDone();
    check(rises == 40, "R9 start ignored while busy", rises, 40);
    check(driveErr == 0, "R9 data unchanged", driveErr, 0);

    summary();
  end
endmodule